// File: doc/BRIEF.md
# DDR2 Data Window Generator

This block sits in the data path of a DDR2-style memory controller. It accepts read and write commands, one per rising clock edge. From the programmed latency settings it works out the cycles in which each access's data phase takes place. It then drives two registered enables, measured in controller clock cycles. One opens the read capture path. The other turns on the write data drivers.

The read delay is the posted additive latency plus the CAS latency. The write delay is one cycle less than the read delay. Each burst's data phase lasts half the burst length in clock cycles, because data moves on both clock edges.

Up to four accesses can be in flight at once, each held in its own slot. This lets back-to-back bursts produce one unbroken window. When all slots are in use, the block raises a busy flag and drops any further command. The latency settings are static configuration inputs. An unsupported setting is flagged, and commands are dropped while the flag is set.

Top module: `ddr2_data_window`

## Requirements
- R1: The read latency RL is `cfg_add_lat + cfg_cas_lat`. For a read accepted at rising edge E, `rd_capture_en` is high in the cycles that follow edges E+RL through E+RL+B-1, where B is the window length defined in R3.
- R2: The write latency WL is RL-1. For a write accepted at edge E, `wr_drive_en` is high in the cycles that follow edges E+WL through E+WL+B-1.
- R3: The window length B is 4 cycles when `cfg_burst8`=1 (burst of 8) and 2 cycles when `cfg_burst8`=0 (burst of 4). An enable is never high unless an access is in flight.
- R4: Two commands of the same direction issued exactly B cycles apart produce one contiguous window of 2*B cycles with no idle cycle between them.
- R5: At most four accesses are in flight. An access stays in flight from the edge that accepts it until the edge that ends its last window cycle. `busy` is high while four are in flight, and a command presented while `busy` is high is dropped and produces no window.
- R6: `cfg_error` is high when `cfg_cas_lat` is outside 3..7 or `cfg_add_lat` is above 6. It follows the configuration one edge later. While it is high, commands are dropped.
- R7: A synchronous active-high `rst` clears every access in flight. From the first reset edge on, both enables and `busy` are low, and they stay low until a new command is accepted.
- R8: Reads and writes in flight at the same time produce their windows independently, each at its own latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cas_lat | input | 3 | CAS latency in cycles (valid 3..7) |
| cfg_add_lat | input | 3 | Posted additive latency in cycles (valid 0..6) |
| cfg_burst8 | input | 1 | 1: burst of 8, 0: burst of 4 |
| cmd_valid | input | 1 | Command present at this rising edge |
| cmd_write | input | 1 | 1: write command, 0: read command |
| rd_capture_en | output | 1 | Read data capture window |
| wr_drive_en | output | 1 | Write data drive window |
| busy | output | 1 | All access slots are occupied; a command is dropped |
| cfg_error | output | 1 | Unsupported latency configuration |

## Verification
The bench counts rising edges from reset and records the edge at which it expects each command to be accepted. It bases that decision on the `busy` and `cfg_error` values it predicts just before that edge.

A read's capture window is due RL edges after acceptance and a write's drive window WL edges after. Each lasts B cycles. `busy` changes on the edge that accepts the fourth access and on the edge that retires one. `cfg_error` follows a configuration change by one edge.

All outputs are sampled on the falling edge, half a cycle after the edge that updates them. The expected values are computed from the edge count against these offsets, so every check lands in the first cycle in which a value is due.

// File: rtl/ddr2_win_pkg.sv
package ddr2_win_pkg;
  // Supported CAS latency range and largest posted additive latency
  localparam int CL_MIN  = 3;
  localparam int CL_MAX  = 7;
  localparam int AL_MAX  = 6;
  // Width holding the largest read latency (AL_MAX + CL_MAX = 13)
  localparam int LAT_W   = 4;
  // Width of the per-slot age counter: must reach latency + window length
  localparam int AGE_W   = 5;
  // Width of a window length in cycles (2 or 4)
  localparam int BLEN_W  = 3;

  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } acc_dir_e;
endpackage

// File: rtl/ddr2_lat_calc.sv
module ddr2_lat_calc
  import ddr2_win_pkg::*;
#(
  parameter int CL_W = 3,
  parameter int AL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CL_W-1:0]   cas_lat,
  input  logic [AL_W-1:0]   add_lat,
  input  logic              burst8,
  output logic [LAT_W-1:0]  rd_lat_q,
  output logic [LAT_W-1:0]  wr_lat_q,
  output logic [BLEN_W-1:0] blen_q,
  output logic              err_q
);
  logic [LAT_W-1:0] rd_lat_d;
  logic             err_d;

  always_comb begin
    rd_lat_d = LAT_W'(add_lat) + LAT_W'(cas_lat);
    err_d    = (int'(cas_lat) < CL_MIN) || (int'(cas_lat) > CL_MAX) ||
               (int'(add_lat) > AL_MAX);
  end

  // Static configuration: pipelined once, not reset, so it settles during reset
  always_ff @(posedge clk) begin
    rd_lat_q <= rd_lat_d;
    wr_lat_q <= rd_lat_d - LAT_W'(1);
    blen_q   <= burst8 ? BLEN_W'(4) : BLEN_W'(2);
    err_q    <= err_d;
  end

  AST_LAT_RANGE: assert property (@(posedge clk) disable iff (rst)
    !err_q |-> (int'(rd_lat_q) >= CL_MIN) && (int'(rd_lat_q) <= CL_MAX + AL_MAX)
                && (int'(wr_lat_q) + 1 == int'(rd_lat_q))); // R2
endmodule

// File: rtl/ddr2_win_slot.sv
module ddr2_win_slot
  import ddr2_win_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              load_wr,
  input  logic [LAT_W-1:0]  lat_in,
  input  logic [BLEN_W-1:0] blen_in,
  output logic              valid_o,
  output logic              win_nxt_o,
  output logic              wr_nxt_o
);
  logic             valid_q, valid_d;
  logic             wr_q, wr_d;
  logic [AGE_W-1:0] age_q, age_d;
  logic [AGE_W-1:0] first_q, first_d;
  logic [AGE_W-1:0] last_q, last_d;

  always_comb begin
    valid_d = valid_q;
    wr_d    = wr_q;
    age_d   = age_q;
    first_d = first_q;
    last_d  = last_q;
    if (load) begin
      valid_d = 1'b1;
      wr_d    = load_wr;
      age_d   = '0;
      first_d = AGE_W'(lat_in);
      last_d  = AGE_W'(lat_in) + AGE_W'(blen_in) - AGE_W'(1);
    end else if (valid_q) begin
      if (age_q == last_q) begin
        valid_d = 1'b0;
      end else begin
        age_d = age_q + AGE_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      wr_q    <= 1'b0;
      age_q   <= '0;
      first_q <= '0;
      last_q  <= '0;
    end else begin
      valid_q <= valid_d;
      wr_q    <= wr_d;
      age_q   <= age_d;
      first_q <= first_d;
      last_q  <= last_d;
    end
  end

  assign valid_o   = valid_q;
  assign wr_nxt_o  = wr_d;
  assign win_nxt_o = valid_d && (age_d >= first_d) && (age_d <= last_d);

  AST_AGE_STEP: assert property (@(posedge clk) disable iff (rst)
    (valid_q && $past(valid_q) && !$past(load)) |-> (age_q == $past(age_q) + AGE_W'(1))); // R1
  AST_RETIRE_AT_END: assert property (@(posedge clk) disable iff (rst)
    $fell(valid_q) |-> ($past(age_q) == $past(last_q))); // R3
endmodule

// File: rtl/ddr2_win_merge.sv
module ddr2_win_merge #(
  parameter int NSLOT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSLOT-1:0] win_nxt,
  input  logic [NSLOT-1:0] wr_nxt,
  output logic             rd_en_q,
  output logic             wr_en_q
);
  logic rd_any, wr_any;

  always_comb begin
    rd_any = 1'b0;
    wr_any = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      rd_any = rd_any | (win_nxt[i] & ~wr_nxt[i]);
      wr_any = wr_any | (win_nxt[i] &  wr_nxt[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en_q <= 1'b0;
      wr_en_q <= 1'b0;
    end else begin
      rd_en_q <= rd_any;
      wr_en_q <= wr_any;
    end
  end
endmodule

// File: rtl/ddr2_data_window.sv
module ddr2_data_window
  import ddr2_win_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int CL_W  = 3,
  parameter int AL_W  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CL_W-1:0] cfg_cas_lat,
  input  logic [AL_W-1:0] cfg_add_lat,
  input  logic            cfg_burst8,
  input  logic            cmd_valid,
  input  logic            cmd_write,
  output logic            rd_capture_en,
  output logic            wr_drive_en,
  output logic            busy,
  output logic            cfg_error
);
  logic [LAT_W-1:0]  rd_lat, wr_lat;
  logic [BLEN_W-1:0] blen;
  logic              err_q;
  logic [NSLOT-1:0]  slot_valid, slot_win_nxt, slot_wr_nxt, alloc_oh, slot_load;
  logic              found, accept;
  logic [LAT_W-1:0]  cmd_lat;

  ddr2_lat_calc #(.CL_W(CL_W), .AL_W(AL_W)) lat_i (
    .clk      (clk),
    .rst      (rst),
    .cas_lat  (cfg_cas_lat),
    .add_lat  (cfg_add_lat),
    .burst8   (cfg_burst8),
    .rd_lat_q (rd_lat),
    .wr_lat_q (wr_lat),
    .blen_q   (blen),
    .err_q    (err_q)
  );

  // Lowest free slot takes the next command
  always_comb begin
    alloc_oh = '0;
    found    = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      if (!slot_valid[i] && !found) begin
        alloc_oh[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  assign busy      = &slot_valid;
  assign cfg_error = err_q;
  assign accept    = cmd_valid && !busy && !err_q;
  assign slot_load = accept ? alloc_oh : '0;
  assign cmd_lat   = (cmd_write == DIR_WRITE) ? wr_lat : rd_lat;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    ddr2_win_slot slot_i (
      .clk       (clk),
      .rst       (rst),
      .load      (slot_load[g]),
      .load_wr   (cmd_write),
      .lat_in    (cmd_lat),
      .blen_in   (blen),
      .valid_o   (slot_valid[g]),
      .win_nxt_o (slot_win_nxt[g]),
      .wr_nxt_o  (slot_wr_nxt[g])
    );
  end

  ddr2_win_merge #(.NSLOT(NSLOT)) merge_i (
    .clk     (clk),
    .rst     (rst),
    .win_nxt (slot_win_nxt),
    .wr_nxt  (slot_wr_nxt),
    .rd_en_q (rd_capture_en),
    .wr_en_q (wr_drive_en)
  );

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && busy) |=> ($countones(slot_valid) <= $past($countones(slot_valid)))); // R5
  AST_ONE_PER_EDGE: assert property (@(posedge clk) disable iff (rst)
    $countones(slot_valid) <= $past($countones(slot_valid)) + 1); // R5
  AST_CFG_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cfg_error) |=> ($countones(slot_valid) <= $past($countones(slot_valid)))); // R6
  AST_WIN_HAS_SLOT: assert property (@(posedge clk) disable iff (rst)
    (rd_capture_en || wr_drive_en) |-> (|slot_valid)); // R3
endmodule

// File: tb/ddr2_data_window_tb.sv
module ddr2_data_window_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cfg_cas_lat = 3'd3;
  logic [2:0] cfg_add_lat = 3'd0;
  logic       cfg_burst8 = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_write = 1'b0;
  logic       rd_capture_en, wr_drive_en, busy, cfg_error;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;
  string cur_tag = "R7";

  localparam int HIST = 4096;
  int acc_t [HIST];
  bit acc_w [HIST];
  int nacc = 0;

  always #5 clk = ~clk;

  ddr2_data_window dut_i (
    .clk           (clk),
    .rst           (rst),
    .cfg_cas_lat   (cfg_cas_lat),
    .cfg_add_lat   (cfg_add_lat),
    .cfg_burst8    (cfg_burst8),
    .cmd_valid     (cmd_valid),
    .cmd_write     (cmd_write),
    .rd_capture_en (rd_capture_en),
    .wr_drive_en   (wr_drive_en),
    .busy          (busy),
    .cfg_error     (cfg_error)
  );

  function automatic bit model_err();
    return (cfg_cas_lat < 3) || (cfg_cas_lat > 7) || (cfg_add_lat > 6);
  endfunction

  // Expected outputs at the current edge count
  task automatic model(output bit erd, output bit ewr, output bit ebusy);
    int rl, wl, b, live, lo;
    rl = int'(cfg_add_lat) + int'(cfg_cas_lat);
    wl = rl - 1;
    b  = cfg_burst8 ? 4 : 2;
    erd = 1'b0; ewr = 1'b0; live = 0;
    lo = (nacc > 8) ? nacc - 8 : 0;
    for (int i = lo; i < nacc; i++) begin
      int n, lat;
      n   = cyc - acc_t[i % HIST];
      lat = acc_w[i % HIST] ? wl : rl;
      if (n <= lat + b - 1) live++;
      if (n >= lat && n <= lat + b - 1) begin
        if (acc_w[i % HIST]) ewr = 1'b1; else erd = 1'b1;
      end
    end
    ebusy = (live >= 4);
  endtask

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s at edge %0d: actual=%0d expected=%0d", cur_tag, what, cyc, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit w);
    bit erd, ewr, ebusy, er, acc;
    @(negedge clk);
    model(erd, ewr, ebusy);
    er = model_err();
    chk("rd_capture_en", int'(rd_capture_en), int'(erd));
    chk("wr_drive_en", int'(wr_drive_en), int'(ewr));
    chk("busy", int'(busy), int'(ebusy));
    chk("cfg_error", int'(cfg_error), int'(er));
    acc = v && !ebusy && !er && !rst;
    cmd_valid = v;
    cmd_write = w;
    @(posedge clk);
    cyc++;
    if (acc) begin
      acc_t[nacc % HIST] = cyc;
      acc_w[nacc % HIST] = w;
      nacc++;
    end
  endtask

  task automatic do_reset(input int k);
    @(negedge clk);
    rst = 1'b1;
    cmd_valid = 1'b0;
    @(posedge clk);
    cyc++;
    nacc = 0;
    repeat (k) step(1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_cfg(input int cl, input int al, input bit b8);
    cfg_cas_lat = 3'(cl);
    cfg_add_lat = 3'(al);
    cfg_burst8  = b8;
  endtask

  task automatic idle(input int k);
    repeat (k) step(1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd715));
    // R7: reset state
    set_cfg(3, 0, 1'b0);
    cur_tag = "R7";
    do_reset(3);
    idle(3);

    // R1 R3: single read, burst of 4 then burst of 8
    cur_tag = "R1 R3";
    step(1'b1, 1'b0); idle(8);
    // R2: single write
    cur_tag = "R2 R3";
    step(1'b1, 1'b1); idle(8);
    set_cfg(5, 2, 1'b1);
    do_reset(2);
    cur_tag = "R1 R2 R3";
    step(1'b1, 1'b0); idle(3); step(1'b1, 1'b1); idle(16);

    // R4: same-direction commands exactly B cycles apart
    set_cfg(4, 1, 1'b0);
    do_reset(2);
    cur_tag = "R4";
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0);
    step(1'b1, 1'b0); idle(12);
    step(1'b1, 1'b1); step(1'b0, 1'b0); step(1'b1, 1'b1); idle(12);
    set_cfg(6, 3, 1'b1);
    do_reset(2);
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b0); idle(3);
    end
    idle(16);

    // R5: flood beyond four in flight
    set_cfg(7, 6, 1'b1);
    do_reset(2);
    cur_tag = "R5";
    for (int i = 0; i < 10; i++) step(1'b1, 1'($urandom_range(1)));
    idle(25);
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0);
    idle(25);

    // R8: random mix of reads and writes across configurations
    cur_tag = "R8";
    for (int k = 0; k < 10; k++) begin
      set_cfg(3 + int'($urandom_range(4)), int'($urandom_range(6)), 1'($urandom_range(1)));
      do_reset(2);
      for (int i = 0; i < 300; i++)
        step(($urandom_range(99) < 45), 1'($urandom_range(1)));
      idle(25);
    end

    // R6: unsupported configurations drop commands
    cur_tag = "R6";
    set_cfg(2, 0, 1'b0); do_reset(2);
    for (int i = 0; i < 6; i++) step(1'b1, 1'($urandom_range(1)));
    idle(12);
    set_cfg(3, 7, 1'b1); do_reset(2);
    for (int i = 0; i < 6; i++) step(1'b1, 1'($urandom_range(1)));
    idle(12);
    set_cfg(0, 2, 1'b0); do_reset(2);
    step(1'b1, 1'b0); idle(12);

    // R7: reset in the middle of traffic
    set_cfg(3, 2, 1'b1); do_reset(2);
    cur_tag = "R7";
    for (int i = 0; i < 4; i++) step(1'b1, 1'($urandom_range(1)));
    idle(2);
    do_reset(2);
    idle(20);
    cur_tag = "R1 R7";
    step(1'b1, 1'b0); idle(12);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule